// File: doc/BRIEF.md
# Paged Address Translation Unit

This unit turns 32-bit virtual addresses into physical addresses through a single-level page table in physical memory. Pages are 1 KB. The low ten address bits pass straight through as the page offset. The upper 22 bits form a virtual page number, and that number selects one 4-byte table entry. The entry supplies a physical page number, a valid flag and three permission flags.

An 8-entry fully associative translation cache holds recent mappings and is searched first. A hit answers one cycle after the request is accepted. On a miss the unit stalls new requests and issues a single read to memory for the entry. It then answers from the fetched entry and, if that entry is valid, installs it in the cache.

Software changes address spaces by loading a new table base. Loading a base, or pulsing flush, empties the cache.

Top module: `xlat_unit`

## Requirements
- R1: A successful translation returns fault code 0. The physical address is the entry's physical page number (entry bits [21:0]) placed above the unchanged virtual bits [9:0].
- R2: On a cache miss, exactly one memory read is issued. It is a one-cycle `mem_req_valid` pulse in the cycle after acceptance, at address table base + virtual page number × 4.
- R3: A cache hit raises `rsp_valid` in the cycle after acceptance and issues no memory read.
- R4: An entry with bit 31 clear returns fault code 1 with a zero physical address. Such an entry is never cached, so a repeat access fetches it again.
- R5: Entry bit 30 permits reads, bit 29 writes and bit 28 instruction fetch. The access kind is coded 0 = read, 1 = write, 2 = fetch, and code 3 is always refused. A refused access returns fault code 2 with a zero address. Valid entries are cached even when they refuse, so a repeat access hits and refuses again.
- R6: `req_ready` stays low from the acceptance of a miss until the cycle in which its response appears. Each accepted request gets exactly one response.
- R7: A flush pulse or a base write invalidates every cached translation in that same cycle. A request accepted in that cycle is treated as a miss.
- R8: After a base write, table reads use the new base.
- R9: Cache slots are filled in round-robin order. After eight installs, the ninth evicts the oldest entry, and the entry installed after it survives.
- R10: A flush or base write while a table read is outstanding still lets that request complete from the fetched entry. The fetched entry is not installed.
- R11: After reset, `req_ready` is high, `rsp_valid` and `mem_req_valid` are low, the cache is empty and the base is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 2 | 0 none, 1 invalid page, 2 protection |
| base_wr | input | 1 | Load new table base |
| base_data | input | 32 | Table base address |
| flush | input | 1 | Invalidate all cached translations |
| mem_req_valid | output | 1 | Table entry read strobe |
| mem_req_addr | output | 32 | Table entry address |
| mem_rsp_valid | input | 1 | Table entry data strobe |
| mem_rsp_data | input | 32 | Table entry |

## Verification
The hardest case to reach from the ports is a flush that lands while a table read is in flight. The walk must still answer, but it must not refill the cache it was told to empty. The bench uses a memory model with a fixed three-cycle latency. It pulses flush in the cycle after a miss is accepted, then repeats the same page and counts memory reads to prove nothing was installed. Round-robin eviction is reached by touching nine distinct pages after a flush, then probing both the oldest page and its successor.

// File: rtl/xlat_pkg.sv
// Shared types for the translation unit: access kinds, fault codes,
// walker states and the entry field positions.
package xlat_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_INVALID = 2'd1,
        FLT_PROT    = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_ISSUE = 2'd1,
        WS_WAIT  = 2'd2
    } walk_state_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } rights_t;

    localparam int PTE_VALID_BIT = 31;
    localparam int PTE_RD_BIT    = 30;
    localparam int PTE_WR_BIT    = 29;
    localparam int PTE_EX_BIT    = 28;
endpackage

// File: rtl/xlat_perm.sv
// Permission check: maps entry validity, rights and access kind to a
// fault code. Purely combinational; assumes kind codes from xlat_pkg.
module xlat_perm
    import xlat_pkg::*;
(
    input  logic       pte_valid,
    input  rights_t    rights,
    input  logic [1:0] kind,
    output logic [1:0] fault
);
    logic allowed;

    // Select the permission flag that the access kind needs.
    always_comb begin
        case (kind)
            ACC_READ:  allowed = rights.rd;
            ACC_WRITE: allowed = rights.wr;
            ACC_FETCH: allowed = rights.ex;
            default:   allowed = 1'b0;
        endcase
    end

    // Invalid entries take precedence over rights.
    always_comb begin
        if (!pte_valid)    fault = FLT_INVALID;
        else if (!allowed) fault = FLT_PROT;
        else               fault = FLT_NONE;
    end
endmodule

// File: rtl/xlat_tcache.sv
// Fully associative translation cache with round-robin refill.
// Assumes at most one entry per page number (only misses install).
// Invalidation wins over a same-cycle install.
module xlat_tcache
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 22,
    parameter int PPN_W   = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output rights_t          lk_rights,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PPN_W-1:0] ins_ppn,
    input  rights_t          ins_rights
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] vld_q;
    logic [VPN_W-1:0]   tag_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];
    rights_t            rts_q [ENTRIES];
    logic [PTR_W-1:0]   rr_q;
    logic [ENTRIES-1:0] match;

    // Valid bits and the refill pointer; invalidation clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            rr_q  <= '0;
        end else if (inv) begin
            vld_q <= '0;
            rr_q  <= '0;
        end else if (ins_en) begin
            vld_q[rr_q] <= 1'b1;
            rr_q        <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end

    // Payload storage, written into the slot the pointer selects.
    always_ff @(posedge clk) begin
        if (ins_en && !inv) begin
            tag_q[rr_q] <= ins_vpn;
            ppn_q[rr_q] <= ins_ppn;
            rts_q[rr_q] <= ins_rights;
        end
    end

    // One comparator per slot.
    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
        assign match[gi] = vld_q[gi] && (tag_q[gi] == lk_vpn);
    end

    // Select the matching slot's payload.
    always_comb begin
        lk_hit    = |match;
        lk_ppn    = '0;
        lk_rights = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                lk_ppn    = ppn_q[i];
                lk_rights = rts_q[i];
            end
        end
    end
endmodule

// File: rtl/xlat_walk.sv
// Table walker: on a miss, issues one read of the table entry at
// base + vpn*4, waits for the data and reports completion. It records
// whether an invalidation happened while it was busy (stale).
// Assumes memory accepts the one-cycle request unconditionally.
module xlat_walk
    import xlat_pkg::*;
#(
    parameter int VPN_W = 22,
    parameter int OFF_W = 10,
    parameter int PA_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VPN_W-1:0] start_vpn,
    input  logic [OFF_W-1:0] start_off,
    input  logic [1:0]       start_kind,
    input  logic             inv,
    input  logic [PA_W-1:0]  base,
    input  logic             mem_rsp_valid,
    output logic             idle,
    output logic             mem_req_valid,
    output logic [PA_W-1:0]  mem_req_addr,
    output logic             done,
    output logic             stale,
    output logic [VPN_W-1:0] vpn,
    output logic [OFF_W-1:0] off,
    output logic [1:0]       kind
);
    walk_state_e state_q;
    logic        stale_q;

    // Walk sequencing: idle -> issue read -> wait for data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
        end else begin
            case (state_q)
                WS_IDLE:  if (start) state_q <= WS_ISSUE;
                WS_ISSUE: state_q <= WS_WAIT;
                WS_WAIT:  if (mem_rsp_valid) state_q <= WS_IDLE;
                default:  state_q <= WS_IDLE;
            endcase
        end
    end

    // Capture the missing request's fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn  <= '0;
            off  <= '0;
            kind <= '0;
        end else if (state_q == WS_IDLE && start) begin
            vpn  <= start_vpn;
            off  <= start_off;
            kind <= start_kind;
        end
    end

    // Remember an invalidation seen while a walk is outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n)                          stale_q <= 1'b0;
        else if (state_q == WS_IDLE)         stale_q <= 1'b0;
        else if (inv)                        stale_q <= 1'b1;
    end

    assign idle          = (state_q == WS_IDLE);
    assign mem_req_valid = (state_q == WS_ISSUE);
    assign mem_req_addr  = base + PA_W'({vpn, 2'b00});
    assign done          = (state_q == WS_WAIT) && mem_rsp_valid;
    assign stale         = stale_q;
endmodule

// File: rtl/xlat_unit.sv
// Paged address translation unit: cache lookup, table walk on miss,
// permission check and a registered response. Pages are 2**OFF_W bytes.
// Assumes the table base is a physical byte address of 4-byte entries.
module xlat_unit
    import xlat_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int OFF_W   = 10,
    parameter int PPN_W   = 22,
    parameter int ENTRIES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [VA_W-1:0]        req_vaddr,
    input  logic [1:0]             req_kind,
    output logic                   rsp_valid,
    output logic [PPN_W+OFF_W-1:0] rsp_paddr,
    output logic [1:0]             rsp_fault,
    input  logic                   base_wr,
    input  logic [PPN_W+OFF_W-1:0] base_data,
    input  logic                   flush,
    output logic                   mem_req_valid,
    output logic [PPN_W+OFF_W-1:0] mem_req_addr,
    input  logic                   mem_rsp_valid,
    input  logic [31:0]            mem_rsp_data
);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PA_W  = PPN_W + OFF_W;

    logic [PA_W-1:0]  base_q;
    logic             inv, accept, hit_raw, hit;
    logic [VPN_W-1:0] lk_vpn;
    logic [OFF_W-1:0] lk_off;
    logic [PPN_W-1:0] hit_ppn;
    rights_t          hit_rights;
    logic [1:0]       hit_fault;

    logic             walk_idle, walk_done, walk_stale;
    logic [VPN_W-1:0] walk_vpn;
    logic [OFF_W-1:0] walk_off;
    logic [1:0]       walk_kind, walk_fault;

    logic             pte_valid;
    rights_t          pte_rights;
    logic [PPN_W-1:0] pte_ppn;

    assign inv       = flush | base_wr;
    assign lk_vpn    = req_vaddr[VA_W-1:OFF_W];
    assign lk_off    = req_vaddr[OFF_W-1:0];
    assign req_ready = walk_idle;
    assign accept    = req_valid & req_ready;
    assign hit       = hit_raw & ~inv;

    assign pte_valid  = mem_rsp_data[PTE_VALID_BIT];
    assign pte_rights = '{rd: mem_rsp_data[PTE_RD_BIT],
                          wr: mem_rsp_data[PTE_WR_BIT],
                          ex: mem_rsp_data[PTE_EX_BIT]};
    assign pte_ppn    = mem_rsp_data[PPN_W-1:0];

    // Table base register.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (base_wr) base_q <= base_data;
    end

    xlat_tcache #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W)
    ) u_cache (
        .clk        (clk),
        .rst_n      (rst_n),
        .inv        (inv),
        .lk_vpn     (lk_vpn),
        .lk_hit     (hit_raw),
        .lk_ppn     (hit_ppn),
        .lk_rights  (hit_rights),
        .ins_en     (walk_done & pte_valid & ~walk_stale),
        .ins_vpn    (walk_vpn),
        .ins_ppn    (pte_ppn),
        .ins_rights (pte_rights)
    );

    xlat_walk #(
        .VPN_W (VPN_W),
        .OFF_W (OFF_W),
        .PA_W  (PA_W)
    ) u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (accept & ~hit),
        .start_vpn     (lk_vpn),
        .start_off     (lk_off),
        .start_kind    (req_kind),
        .inv           (inv),
        .base          (base_q),
        .mem_rsp_valid (mem_rsp_valid),
        .idle          (walk_idle),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .done          (walk_done),
        .stale         (walk_stale),
        .vpn           (walk_vpn),
        .off           (walk_off),
        .kind          (walk_kind)
    );

    xlat_perm u_perm_hit (
        .pte_valid (1'b1),
        .rights    (hit_rights),
        .kind      (req_kind),
        .fault     (hit_fault)
    );

    xlat_perm u_perm_walk (
        .pte_valid (pte_valid),
        .rights    (pte_rights),
        .kind      (walk_kind),
        .fault     (walk_fault)
    );

    // Registered response from either the hit path or a finished walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= FLT_NONE;
        end else begin
            rsp_valid <= 1'b0;
            if (accept && hit) begin
                rsp_valid <= 1'b1;
                rsp_fault <= hit_fault;
                rsp_paddr <= (hit_fault == FLT_NONE) ? {hit_ppn, lk_off} : '0;
            end else if (walk_done) begin
                rsp_valid <= 1'b1;
                rsp_fault <= walk_fault;
                rsp_paddr <= (walk_fault == FLT_NONE) ? {pte_ppn, walk_off} : '0;
            end
        end
    end
endmodule

// File: rtl/xlat_unit_chk.sv
// Checker for xlat_unit, bound to every instance. Tracks the accepted
// offset and outstanding-request state from the ports only.
module xlat_unit_chk #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 10,
    parameter int PA_W  = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic            rsp_valid,
    input logic [PA_W-1:0] rsp_paddr,
    input logic [1:0]      rsp_fault,
    input logic            mem_req_valid
);
    logic             pend_q;
    logic [OFF_W-1:0] off_q;
    logic             accept;

    assign accept = req_valid && req_ready;

    // Outstanding request flag and its page offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            off_q  <= '0;
        end else begin
            pend_q <= accept || (pend_q && !rsp_valid);
            if (accept) off_q <= req_vaddr[OFF_W-1:0];
        end
    end

    AST_RSP_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> pend_q);                                         // R6
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (!pend_q || rsp_valid));                            // R6
    AST_STALL_ON_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);                                 // R6
    AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);                             // R2
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'd0) |-> rsp_paddr[OFF_W-1:0] == off_q); // R1
    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> rsp_paddr == '0);         // R4
    AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_fault != 2'd3);                              // R5
endmodule

bind xlat_unit xlat_unit_chk #(
    .VA_W  (VA_W),
    .OFF_W (OFF_W),
    .PA_W  (PPN_W + OFF_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault),
    .mem_req_valid (mem_req_valid)
);

// File: tb/xlat_unit_bench.sv
`timescale 1ns/1ps
module xlat_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        base_wr = 1'b0;
    logic [31:0] base_data = '0;
    logic        flush = 1'b0;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    int tests = 0;
    int fails = 0;
    int mem_reads;
    logic [31:0] last_addr;
    int lat_cnt;
    logic [31:0] cur_base = '0;

    always #2 clk = ~clk;

    xlat_unit u_xlat_unit (.*);

    // Memory model: entry content is a function of its address.
    function automatic logic [31:0] pte_of(input logic [31:0] a);
        logic [29:0] w;
        w = a[31:2];
        return {(w[5:3] != 3'b111), w[2:0], 6'b0, w[21:0] ^ 22'h2A5A5};
    endfunction

    function automatic logic [31:0] exp_paddr(input logic [31:0] base,
                                              input logic [31:0] va,
                                              input logic [1:0]  f);
        logic [31:0] e;
        e = pte_of(base + {8'd0, va[31:10], 2'b00});
        return (f == 2'd0) ? {e[21:0], va[9:0]} : 32'd0;
    endfunction

    // Fixed three-cycle latency memory.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_reads     <= 0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
            last_addr     <= '0;
            lat_cnt       <= 0;
        end else begin
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid) begin
                mem_reads <= mem_reads + 1;
                last_addr <= mem_req_addr;
                lat_cnt   <= 3;
            end else if (lat_cnt != 0) begin
                lat_cnt <= lat_cnt - 1;
                if (lat_cnt == 1) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= pte_of(last_addr);
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One translation; fmode 1 flushes in the accept cycle, 2 one cycle later.
    task automatic xact(input logic [31:0] va, input logic [1:0] k, input int fmode,
                        output logic [31:0] pa, output logic [1:0] f,
                        output int lat, output int reads, output bit stall_ok);
        int r0;
        r0 = mem_reads;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = k;
        if (fmode == 1) flush = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; flush = 1'b0;
        lat = 1; stall_ok = 1'b1;
        if (fmode == 2) flush = 1'b1;
        while (!rsp_valid) begin
            if (req_ready) stall_ok = 1'b0;
            @(negedge clk);
            flush = 1'b0;
            lat++;
        end
        pa = rsp_paddr; f = rsp_fault; reads = mem_reads - r0;
    endtask

    task automatic set_base(input logic [31:0] b);
        @(negedge clk);
        base_wr = 1'b1; base_data = b;
        @(negedge clk);
        base_wr = 1'b0;
        cur_base = b;
    endtask

    // {vaddr, kind, expected fault, expected hit}
    localparam int NV = 13;
    localparam logic [36:0] VEC [NV] = '{
        {32'h0000_1C35, 2'd0, 2'd0, 1'b0},
        {32'h0000_1FFF, 2'd1, 2'd0, 1'b1},
        {32'h0000_1C00, 2'd2, 2'd0, 1'b1},
        {32'h0000_0410, 2'd0, 2'd2, 1'b0},
        {32'h0000_07FF, 2'd2, 2'd0, 1'b1},
        {32'h0000_E123, 2'd0, 2'd1, 1'b0},
        {32'h0000_E000, 2'd2, 2'd1, 1'b0},
        {32'h0000_1004, 2'd1, 2'd2, 1'b0},
        {32'h0000_13FC, 2'd0, 2'd0, 1'b1},
        {32'h0000_1C01, 2'd3, 2'd2, 1'b1},
        {32'h0000_0A55, 2'd1, 2'd0, 1'b0},
        {32'h0000_0A55, 2'd0, 2'd2, 1'b1},
        {32'hFFFF_1EAB, 2'd0, 2'd0, 1'b0}
    };

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        summary();
    end

    initial begin
        logic [31:0] pa;
        logic [1:0]  f;
        int lat, reads;
        bit st;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check(req_ready == 1'b1, "R11 ready", {31'd0, req_ready}, 32'd1);
        check(rsp_valid == 1'b0, "R11 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check(mem_req_valid == 1'b0, "R11 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);

        // Vector table: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            logic [31:0] va;
            logic [1:0]  k, ef;
            logic        eh;
            {va, k, ef, eh} = VEC[i];
            xact(va, k, 0, pa, f, lat, reads, st);
            check(f == ef, "R5/R4 fault", {30'd0, f}, {30'd0, ef});
            check(pa == exp_paddr(cur_base, va, ef), "R1 paddr", pa,
                  exp_paddr(cur_base, va, ef));
            if (eh) begin
                check(reads == 0 && lat == 1, "R3 hit timing", lat, 1);
            end else begin
                check(reads == 1, "R2 one read", reads, 1);
                check(last_addr == cur_base + {8'd0, va[31:10], 2'b00}, "R2 addr",
                      last_addr, cur_base + {8'd0, va[31:10], 2'b00});
                check(st, "R6 stall", {31'd0, st}, 32'd1);
            end
        end

        // R7: flush alone empties the cache
        xact(32'h0000_1C10, 2'd0, 0, pa, f, lat, reads, st);
        check(reads == 0, "R7 pre-flush hit", reads, 0);
        @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0;
        xact(32'h0000_1C10, 2'd0, 0, pa, f, lat, reads, st);
        check(reads == 1, "R7 miss after flush", reads, 1);
        // R7: flush in the accept cycle forces a miss
        xact(32'h0000_1C10, 2'd0, 1, pa, f, lat, reads, st);
        check(reads == 1, "R7 same-cycle flush", reads, 1);

        // R8: new base moves table reads and invalidates
        set_base(32'h0004_0000);
        xact(32'h0000_1C22, 2'd0, 0, pa, f, lat, reads, st);
        check(reads == 1, "R8 miss after base write", reads, 1);
        check(last_addr == 32'h0004_001C, "R8 addr", last_addr, 32'h0004_001C);
        check(pa == exp_paddr(cur_base, 32'h0000_1C22, 2'd0), "R8 paddr", pa,
              exp_paddr(cur_base, 32'h0000_1C22, 2'd0));

        // R10: flush during outstanding read; response kept, no install
        xact(32'h0000_2444, 2'd2, 2, pa, f, lat, reads, st);
        check(f == 2'd0 && pa == exp_paddr(cur_base, 32'h0000_2444, 2'd0),
              "R10 response", pa, exp_paddr(cur_base, 32'h0000_2444, 2'd0));
        xact(32'h0000_2444, 2'd2, 0, pa, f, lat, reads, st);
        check(reads == 1, "R10 not installed", reads, 1);
        xact(32'h0000_E000, 2'd0, 0, pa, f, lat, reads, st);
        xact(32'h0000_E000, 2'd0, 0, pa, f, lat, reads, st);
        check(reads == 1, "R4 invalid refetched", reads, 1);

        // R9: round-robin eviction
        @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0;
        for (int v = 16; v <= 24; v++) begin
            xact({22'(v), 10'h0}, 2'd0, 0, pa, f, lat, reads, st);
        end
        xact({22'd16, 10'h0}, 2'd0, 0, pa, f, lat, reads, st);
        check(reads == 1, "R9 oldest evicted", reads, 1);
        xact({22'd18, 10'h0}, 2'd0, 0, pa, f, lat, reads, st);
        check(reads == 0, "R9 successor kept", reads, 0);

        summary();
    end
endmodule